// File: doc/BRIEF.md
# Status Stack Pointer Update Controller

This block keeps the 64-bit stack pointer doubleword that a privileged save-context and restore-context mechanism relies on. The doubleword carries a top-of-stack word address, a space count and a word count. Each count has a sticky overflow flag. A save operation streams a fixed 28-word processor context into memory one word at a time. The context consists of status words and sixteen general registers. The block then fetches two new status words from an effective address supplied with the request. A restore operation reads the same 28 words back in reverse order and hands each one to the register side.

Before a restore starts, the block looks at the word count and chooses one of three paths. The first is a normal stack read. The second is a fallback fetch of two default status words from fixed low addresses, which leaves the doubleword untouched. The third is an instruction-exception trap request, which also leaves the doubleword untouched. Counts step by one per transferred word. An overflow only raises its flag and never stops a transfer. Software reloads the whole doubleword through a direct-write port, and that port is the only way to clear a flag. Memory is reached through a word-wide request/grant interface.

Top module: `ssp_ctrl`

## Requirements
- R1: After reset the doubleword reads zero, busy, done, trap_req, ctx_load and psw_load are low, and no memory request is raised.
- R2: Doubleword layout: word count in bits 14:0, word-count overflow flag in bit 15, space count in bits 30:16, space-count overflow flag in bit 31, top-of-stack address in bits 63:32. When wr_en is high while idle, the doubleword is loaded from wr_data the next cycle. This clears or sets both flags. When wr_en is high while busy, it is ignored.
- R3: A save writes context word k (k = 0..27, ascending; ctx_idx shows k) to address tos+1+k. When it completes, tos has risen by 28, the word count has risen by 28 and the space count has fallen by 28, both counts modulo 32768.
- R4: When the word count passes 32767 during a save, it wraps and its flag becomes 1, and the save still finishes. A later restore never clears that flag.
- R5: A restore whose starting word count is 28 or more reads addresses tos, tos-1, ... tos-27 and delivers them with ctx_ld_idx 27 down to 0. When it completes, tos and the word count have fallen by 28 and the space count has risen by 28.
- R6: When the space count passes 32767 during a restore, it wraps and its flag becomes 1, and the restore still finishes. The decrements of a later save never clear that flag. Only a direct write does.
- R7: After the 28 writes, a save reads push_ea then push_ea+1 and delivers them as status word 0 and status word 1 (psw_sel 0 then 1).
- R8: A restore with a starting word count of zero leaves the doubleword unchanged, reads addresses 2 and 3 as status words 0 and 1, and raises no trap.
- R9: A restore with a starting word count from 1 to 27 makes no memory access and leaves the doubleword unchanged. In the cycle after the request it pulses trap_req with trap_vec = 8'h4D, trap_cc2 = 1 and done.
- R10: done pulses for one cycle at the end of every operation. When push_req and pull_req arrive together, the save is chosen. A request is ignored while busy or when wr_en is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Direct write of the doubleword |
| wr_data | input | 64 | Doubleword value for a direct write |
| push_req | input | 1 | Start a save (single-cycle pulse) |
| pull_req | input | 1 | Start a restore (single-cycle pulse) |
| push_ea | input | 32 | Address of the new status word pair for a save |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| trap_req | output | 1 | Instruction-exception trap request |
| trap_vec | output | 8 | Trap location, 8'h4D |
| trap_cc2 | output | 1 | Condition-code bit 2 set request, with trap_req |
| ssp | output | 64 | Current stack pointer doubleword |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| mem_gnt | input | 1 | Access accepted this cycle |
| ctx_idx | output | 5 | Context word currently being transferred |
| ctx_wdata | input | 32 | Context word selected by ctx_idx |
| ctx_load | output | 1 | A restored context word is valid |
| ctx_ld_idx | output | 5 | Index of the restored context word |
| ctx_data | output | 32 | Restored context word |
| psw_load | output | 1 | A status word is valid |
| psw_sel | output | 1 | Which status word (0 or 1) |
| psw_data | output | 32 | Status word value |

## Verification
The assertions assume that push_req and pull_req are single-cycle pulses. They also assume that mem_gnt is only ever high together with mem_req. If a request were held high, back-to-back trap outcomes could produce consecutive done cycles. The stimulus pulses each request for exactly one cycle and waits for done before issuing the next. It derives the grant as mem_req ANDed with a bench pattern, and that pattern is either always-on or alternating. The stimulus also keeps every top-of-stack value at least 28 and inside a small memory window, so that restore addresses never wrap.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_PULL = 2'd2,
    ST_PSW  = 2'd3
  } ssp_state_e;
endpackage

// File: rtl/ssp_cnt_step.sv
module ssp_cnt_step #(
  parameter int CNT_W = 15
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic             up_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W:0] ext;
  logic [CNT_W:0] res;

  always_comb begin
    ext = {1'b0, cnt_i};
    if (up_i) res = ext + (CNT_W+1)'(1);
    else      res = ext - (CNT_W+1)'(1);
    cnt_o = res[CNT_W-1:0];
    // carry out only counts as overflow when stepping upward
    ovf_o = ovf_i | (up_i & res[CNT_W]);
  end
endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
  import ssp_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int FRAME_WORDS = 28,
  parameter int DFLT_BASE   = 2,
  localparam int IDX_W      = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pull_req,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wc_i,
  input  logic [ADDR_W-1:0] tos_i,
  input  logic [ADDR_W-1:0] push_ea,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [IDX_W-1:0]  ctx_idx,
  output logic              step_en,
  output logic              step_up,
  output logic              ctx_load,
  output logic [IDX_W-1:0]  ctx_ld_idx,
  output logic [DATA_W-1:0] ctx_data,
  output logic              psw_load,
  output logic              psw_sel,
  output logic [DATA_W-1:0] psw_data,
  output logic              done,
  output logic              trap_req
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_WORDS);

  ssp_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic              pk;
  logic [ADDR_W-1:0] base;

  assign busy    = (state != ST_IDLE);
  assign mem_req = busy;
  assign mem_we  = (state == ST_PUSH);
  assign ctx_idx = idx;
  assign step_en = mem_gnt & ((state == ST_PUSH) | (state == ST_PULL));
  assign step_up = (state == ST_PUSH);

  always_comb begin
    case (state)
      ST_PUSH: mem_addr = tos_i + ADDR_W'(1);
      ST_PULL: mem_addr = tos_i;
      ST_PSW:  mem_addr = base + ADDR_W'(pk);
      default: mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      pk         <= 1'b0;
      base       <= '0;
      done       <= 1'b0;
      trap_req   <= 1'b0;
      ctx_load   <= 1'b0;
      ctx_ld_idx <= '0;
      ctx_data   <= '0;
      psw_load   <= 1'b0;
      psw_sel    <= 1'b0;
      psw_data   <= '0;
    end else begin
      done     <= 1'b0;
      trap_req <= 1'b0;
      ctx_load <= 1'b0;
      psw_load <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (!wr_en) begin
            if (push_req) begin
              state <= ST_PUSH;
              idx   <= '0;
              base  <= push_ea;
            end else if (pull_req) begin
              if (wc_i == '0) begin
                state <= ST_PSW;
                pk    <= 1'b0;
                base  <= ADDR_W'(DFLT_BASE);
              end else if (wc_i < FRAME_CNT) begin
                trap_req <= 1'b1;
                done     <= 1'b1;
              end else begin
                state <= ST_PULL;
                idx   <= LAST_IDX;
              end
            end
          end
        end
        ST_PUSH: begin
          if (mem_gnt) begin
            if (idx == LAST_IDX) begin
              state <= ST_PSW;
              pk    <= 1'b0;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
        end
        ST_PULL: begin
          if (mem_gnt) begin
            ctx_load   <= 1'b1;
            ctx_ld_idx <= idx;
            ctx_data   <= mem_rdata;
            if (idx == '0) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              idx <= idx - IDX_W'(1);
            end
          end
        end
        default: begin
          if (mem_gnt) begin
            psw_load <= 1'b1;
            psw_sel  <= pk;
            psw_data <= mem_rdata;
            if (pk) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              pk <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int CNT_W          = 15,
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int FRAME_WORDS    = 28,
  parameter int DFLT_BASE      = 2,
  parameter logic [7:0] TRAP_VEC = 8'h4D,
  localparam int DW_W          = ADDR_W + 2 * (CNT_W + 1),
  localparam int IDX_W         = $clog2(FRAME_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DW_W-1:0]   wr_data,
  input  logic              push_req,
  input  logic              pull_req,
  input  logic [ADDR_W-1:0] push_ea,
  output logic              busy,
  output logic              done,
  output logic              trap_req,
  output logic [7:0]        trap_vec,
  output logic              trap_cc2,
  output logic [DW_W-1:0]   ssp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_gnt,
  output logic [IDX_W-1:0]  ctx_idx,
  input  logic [DATA_W-1:0] ctx_wdata,
  output logic              ctx_load,
  output logic [IDX_W-1:0]  ctx_ld_idx,
  output logic [DATA_W-1:0] ctx_data,
  output logic              psw_load,
  output logic              psw_sel,
  output logic [DATA_W-1:0] psw_data
);
  localparam int WC_LSB  = 0;
  localparam int WOV_BIT = CNT_W;
  localparam int SC_LSB  = CNT_W + 1;
  localparam int SOV_BIT = 2 * CNT_W + 1;
  localparam int TOS_LSB = 2 * CNT_W + 2;

  logic [DW_W-1:0]   ssp_q;
  logic [CNT_W-1:0]  wc, sc, wc_n, sc_n;
  logic              wov, sov, wov_n, sov_n;
  logic [ADDR_W-1:0] tos, tos_n;
  logic              step_en, step_up, wr_ok;

  assign wc  = ssp_q[WC_LSB +: CNT_W];
  assign wov = ssp_q[WOV_BIT];
  assign sc  = ssp_q[SC_LSB +: CNT_W];
  assign sov = ssp_q[SOV_BIT];
  assign tos = ssp_q[TOS_LSB +: ADDR_W];

  // word count rises on save, space count falls; reversed on restore
  ssp_cnt_step #(.CNT_W(CNT_W)) u_wc (
    .cnt_i(wc), .ovf_i(wov), .up_i(step_up), .cnt_o(wc_n), .ovf_o(wov_n)
  );
  ssp_cnt_step #(.CNT_W(CNT_W)) u_sc (
    .cnt_i(sc), .ovf_i(sov), .up_i(~step_up), .cnt_o(sc_n), .ovf_o(sov_n)
  );

  assign tos_n = step_up ? (tos + ADDR_W'(1)) : (tos - ADDR_W'(1));

  ssp_fsm #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .FRAME_WORDS(FRAME_WORDS), .DFLT_BASE(DFLT_BASE)
  ) u_fsm (
    .clk(clk), .rst(rst), .push_req(push_req), .pull_req(pull_req),
    .wr_en(wr_en), .wc_i(wc), .tos_i(tos), .push_ea(push_ea),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .ctx_idx(ctx_idx), .step_en(step_en), .step_up(step_up),
    .ctx_load(ctx_load), .ctx_ld_idx(ctx_ld_idx), .ctx_data(ctx_data),
    .psw_load(psw_load), .psw_sel(psw_sel), .psw_data(psw_data),
    .done(done), .trap_req(trap_req)
  );

  assign wr_ok = wr_en & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ssp_q <= '0;
    end else if (wr_ok) begin
      ssp_q <= wr_data;
    end else if (step_en) begin
      ssp_q <= {tos_n, sov_n, sc_n, wov_n, wc_n};
    end
  end

  assign ssp       = ssp_q;
  assign mem_wdata = ctx_wdata;
  assign trap_vec  = TRAP_VEC;
  assign trap_cc2  = trap_req;
endmodule

// File: rtl/ssp_ctrl_chk.sv
module ssp_ctrl_chk #(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 32,
  localparam int DW_W  = ADDR_W + 2 * (CNT_W + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            busy,
  input logic            done,
  input logic            trap_req,
  input logic [7:0]      trap_vec,
  input logic            trap_cc2,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_gnt,
  input logic [DW_W-1:0] ssp
);
  localparam int WOV_BIT = CNT_W;
  localparam int SOV_BIT = 2 * CNT_W + 1;
  localparam int TOS_LSB = 2 * CNT_W + 2;

  logic [ADDR_W-1:0] tos;
  assign tos = ssp[TOS_LSB +: ADDR_W];

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R1
  AST_TRAP_FORM: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (trap_vec == 8'h4D) && trap_cc2 && done); // R9
  AST_TRAP_KEEP: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> ssp == $past(ssp)); // R9
  AST_WOV_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(ssp[WOV_BIT]) && !$past(wr_en)) |-> ssp[WOV_BIT]); // R4
  AST_SOV_STICKY: assert property (@(posedge clk) disable iff (rst)
    ($past(ssp[SOV_BIT]) && !$past(wr_en)) |-> ssp[SOV_BIT]); // R6
  AST_PUSH_TOS_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_gnt) |=> tos == $past(tos) + ADDR_W'(1)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
endmodule

bind ssp_ctrl ssp_ctrl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .busy(busy), .done(done),
  .trap_req(trap_req), .trap_vec(trap_vec), .trap_cc2(trap_cc2),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .ssp(ssp)
);

// File: tb/tb_ssp_ctrl.sv
`timescale 1ns/1ps
module tb_ssp_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        push_req = 1'b0, pull_req = 1'b0;
  logic [31:0] push_ea = '0;
  logic        busy, done, trap_req, trap_cc2;
  logic [7:0]  trap_vec;
  logic [63:0] ssp;
  logic        mem_req, mem_we, mem_gnt;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [4:0]  ctx_idx, ctx_ld_idx;
  logic [31:0] ctx_wdata, ctx_data, psw_data;
  logic        ctx_load, psw_load, psw_sel;

  int checks = 0, errors = 0;
  logic [7:0]  tag = 8'h00;
  logic        gnt_alt = 1'b0, gnt_tog = 1'b0;
  logic [31:0] mem [1024];
  logic [31:0] pulled [28];
  logic [31:0] psw_got [2];
  int pull_loads, psw_loads, trap_seen, acc_cnt, done_cnt;
  logic [7:0] vec_seen;
  logic       cc2_seen;

  always #2.5 clk = ~clk;

  ssp_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .push_req(push_req), .pull_req(pull_req), .push_ea(push_ea),
    .busy(busy), .done(done), .trap_req(trap_req), .trap_vec(trap_vec),
    .trap_cc2(trap_cc2), .ssp(ssp), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_gnt(mem_gnt), .ctx_idx(ctx_idx), .ctx_wdata(ctx_wdata),
    .ctx_load(ctx_load), .ctx_ld_idx(ctx_ld_idx), .ctx_data(ctx_data),
    .psw_load(psw_load), .psw_sel(psw_sel), .psw_data(psw_data)
  );

  function automatic logic [31:0] ctx_pat(input logic [7:0] t, input logic [4:0] k);
    return {8'hA5, t, 11'd0, k};
  endfunction
  function automatic logic [31:0] mem_init(input int a);
    return 32'h5000_0000 | a;
  endfunction

  assign ctx_wdata = ctx_pat(tag, ctx_idx);
  assign mem_gnt   = mem_req & (!gnt_alt | gnt_tog);
  assign mem_rdata = mem[mem_addr[9:0]];

  always @(negedge clk) gnt_tog <= ~gnt_tog;

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end
  end

  always @(posedge clk) begin
    #1;
    if (ctx_load) begin pulled[ctx_ld_idx] = ctx_data; pull_loads++; end
    if (psw_load) begin psw_got[psw_sel] = psw_data; psw_loads++; end
    if (trap_req) begin trap_seen++; vec_seen = trap_vec; cc2_seen = trap_cc2; end
    if (done) done_cnt++;
  end

  function automatic logic [63:0] mk(input logic [31:0] tos, input logic sov,
                                     input int sc, input logic wov, input int wc);
    logic [31:0] s, w;
    s = sc; w = wc;
    return {tos, sov, s[14:0], wov, w[14:0]};
  endfunction
  function automatic logic [63:0] exp_push(input logic [63:0] v);
    int wsum;
    wsum = int'(v[14:0]) + 28;
    return mk(v[63:32] + 32'd28, v[31], int'(v[30:16]) - 28, v[15] | (wsum > 32767), wsum);
  endfunction
  function automatic logic [63:0] exp_pull(input logic [63:0] v);
    int ssum;
    ssum = int'(v[30:16]) + 28;
    return mk(v[63:32] - 32'd28, v[31] | (ssum > 32767), ssum, v[15], int'(v[14:0]) - 28);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    pull_loads = 0; psw_loads = 0; trap_seen = 0; acc_cnt = 0; done_cnt = 0;
    vec_seen = '0; cc2_seen = 1'b0;
  endtask

  task automatic wr_ssp(input logic [63:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // kind: 0 save, 1 restore, 2 both requests; poke injects a write and a request mid-op
  task automatic run_op(input int kind, input logic [31:0] ea, input bit poke);
    clr_mon();
    @(negedge clk);
    push_req = (kind != 1); pull_req = (kind != 0); push_ea = ea;
    @(negedge clk);
    push_req = 1'b0; pull_req = 1'b0;
    if (poke) begin
      wr_en = 1'b1; wr_data = 64'hDEAD_BEEF_1234_5678; pull_req = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; pull_req = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v, e;
    for (int a = 0; a < 1024; a++) mem[a] = mem_init(a);
    clr_mon();
    repeat (3) @(negedge clk);
    chk("R1 ssp after reset", ssp, 64'd0);
    chk("R1 outputs after reset", {busy, done, trap_req, ctx_load, psw_load, mem_req}, 6'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after release", {busy, mem_req}, 2'd0);

    v = mk(32'd200, 1'b0, 1000, 1'b0, 0);
    wr_ssp(v);
    chk("R2 direct write", ssp, v);

    tag = 8'h11; mem[600] = 32'hCAFE_0000; mem[601] = 32'hCAFE_0001;
    run_op(0, 32'd600, 1'b0);
    chk("R3 save doubleword", ssp, exp_push(v));
    for (int k = 0; k < 28; k++)
      chk("R3 save memory image", mem[201 + k], ctx_pat(8'h11, 5'(k)));
    chk("R7 status word 0", psw_got[0], 32'hCAFE_0000);
    chk("R7 status word 1", psw_got[1], 32'hCAFE_0001);
    chk("R10 one done per save", done_cnt, 1);

    v = ssp;
    gnt_alt = 1'b1;
    run_op(1, 32'd0, 1'b0);
    chk("R5 restore doubleword", ssp, exp_pull(v));
    chk("R5 restore word count", pull_loads, 28);
    for (int k = 0; k < 28; k++)
      chk("R5 restored context", pulled[k], ctx_pat(8'h11, 5'(k)));

    v = ssp;
    run_op(1, 32'd0, 1'b0);
    chk("R8 zero count keeps doubleword", ssp, v);
    chk("R8 default word 0", psw_got[0], mem_init(2));
    chk("R8 default word 1", psw_got[1], mem_init(3));
    chk("R8 no trap", trap_seen, 0);

    // save with word count wrapping past 32767
    v = mk(32'd300, 1'b0, 5, 1'b0, 32760);
    wr_ssp(v);
    tag = 8'h22;
    run_op(0, 32'd610, 1'b0);
    chk("R4 word count wrap on save", ssp, mk(32'd328, 1'b0, 32745, 1'b1, 20));
    v = mk(32'd328, 1'b0, 5, 1'b1, 100);
    wr_ssp(v);
    run_op(1, 32'd0, 1'b0);
    chk("R4 flag kept through restore", ssp, exp_pull(v));

    // restore with space count wrapping past 32767
    gnt_alt = 1'b0;
    v = mk(32'd500, 1'b0, 32760, 1'b0, 40);
    wr_ssp(v);
    run_op(1, 32'd0, 1'b0);
    e = mk(32'd472, 1'b1, 20, 1'b0, 12);
    chk("R6 space count wrap on restore", ssp, e);
    tag = 8'h33;
    run_op(0, 32'd610, 1'b0);
    chk("R6 flag kept through save", ssp, exp_push(e));
    v = mk(32'd500, 1'b0, 7, 1'b0, 40);
    wr_ssp(v);
    chk("R6 direct write clears flags", ssp, v);

    // write and request while busy must be ignored
    v = mk(32'd40, 1'b0, 9000, 1'b0, 3);
    wr_ssp(v);
    run_op(0, 32'd620, 1'b1);
    chk("R2 write ignored while busy", ssp, exp_push(v));
    chk("R10 request ignored while busy", done_cnt, 1);

    // both requests together: save wins
    v = ssp;
    run_op(2, 32'd620, 1'b0);
    chk("R10 save has priority", ssp, exp_push(v));

    // request in the same cycle as a direct write is dropped
    clr_mon();
    v = mk(32'd900, 1'b0, 50, 1'b0, 60);
    @(negedge clk); wr_en = 1'b1; wr_data = v; push_req = 1'b1;
    @(negedge clk); wr_en = 1'b0; push_req = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 request dropped with write", {done_cnt[7:0], acc_cnt[7:0]}, 16'd0);
    chk("R2 write taken over request", ssp, v);

    // sweep restore decision across word counts 0..40
    for (int w = 0; w <= 40; w++) begin
      v = mk(32'd800, 1'b0, 100, 1'b0, w);
      wr_ssp(v);
      run_op(1, 32'd0, 1'b0);
      if (w == 0) begin
        chk("R8 sweep zero count", {ssp, 8'(psw_loads), 8'(trap_seen)}, {v, 8'd2, 8'd0});
      end else if (w < 28) begin
        chk("R9 sweep doubleword kept", ssp, v);
        chk("R9 sweep trap form", {8'(trap_seen), vec_seen, 7'd0, cc2_seen, 8'(acc_cnt)},
            {8'd1, 8'h4D, 8'd1, 8'd0});
      end else begin
        chk("R5 sweep doubleword", ssp, exp_pull(v));
        chk("R5 sweep first word", pulled[27], mem_init(800));
        chk("R5 sweep last word", pulled[0], mem_init(773));
        chk("R10 sweep single done", done_cnt, 1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule